// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the mode sequencer of a single-wire bus transceiver. It keeps the device in one of three operating modes: sleep, standby and normal. It also derives the enables for the pin drivers around it. The only inputs are the mode-select level from the host and a one-cycle wake pulse from a separate wake detector. The host requests normal operation by holding the select level high, and requests sleep by holding it low. Each request is qualified by its own filter time, counted in clock cycles.

Two details matter for system integration. First, when the select level rises in standby, the TxD pull-down and the RxD pin are reconfigured in the same cycle, without waiting for the filter. This stops a strong pull-down from fighting a host that is already driving TxD high. Second, a wake pulse that arrives while the low-level filter is running in normal mode is treated as a real wake-up. The device then goes to standby instead of sleep. All control pins are plain levels, and no interface here carries streamed data.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While reset is asserted and afterwards, until the first transition, the mode is standby (mode_o = 1, with encoding 0 = sleep, 1 = standby, 2 = normal) and the inhibit output is driven (inh_en_o = 1).
- R2: From sleep or standby, mode_o becomes 2 on the clock edge at which en_i has been sampled high on EN_FILT consecutive edges.
- R3: From normal, mode_o becomes 0 on the clock edge at which en_i has been sampled low on DIS_FILT consecutive edges, unless R10 applies.
- R4: A change of en_i level before its filter count completes restarts the count, so no transition happens.
- R5: In standby, the pins follow en_i in the same cycle. When en_i = 1: weak pull-down (txd_pd_strong_o = 0) and RxD high-impedance (rxd_hiz_o = 1). When en_i = 0: strong pull-down and RxD driven low (rxd_hiz_o = 0).
- R6: In sleep: inh_en_o = 0 (inhibit high-impedance), rxd_hiz_o = 1, txd_pd_strong_o = 0.
- R7: In normal: inh_en_o = 1, txd_pd_strong_o = 0, rxd_hiz_o = 0.
- R8: wake_det_en_o = 1 exactly in sleep, or in normal while en_i = 0.
- R9: A wake pulse in sleep moves the mode to standby on the next edge. If the enable filter completes on that same edge, normal wins.
- R10: A wake pulse in normal while en_i = 0 moves the mode to standby on the next edge. This takes priority over sleep entry, even when the disable filter completes on that edge.
- R11: A wake pulse in standby, or in normal while en_i = 1, leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| en_i | input | 1 | Mode-select level from host |
| wake_i | input | 1 | One-cycle wake pulse from the wake detector |
| mode_o | output | 2 | Current mode: 0 sleep, 1 standby, 2 normal |
| inh_en_o | output | 1 | 1 = inhibit output driven, 0 = high-impedance |
| txd_pd_strong_o | output | 1 | 1 = strong TxD pull-down, 0 = weak |
| rxd_hiz_o | output | 1 | 1 = RxD high-impedance, 0 = RxD driven |
| wake_det_en_o | output | 1 | Enables the external wake detector |

## Verification
The main function is exercised with four kinds of en_i pattern:
- Held levels, which show the exact edge on which each filter completes.
- Pulses one cycle shorter than a filter, which separate a restarting count from a cumulative one.
- Short opposite-level glitches inside a running filter.
- A rise in standby followed by a drop, which shows the pins switching ahead of the mode.

Wake pulses are placed in every mode, both early in the disable window and on the very edge where each filter completes. This pins down the two priority rules and the cases where a wake is ignored.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'd0,
    MODE_STANDBY = 2'd1,
    MODE_NORMAL  = 2'd2
  } mode_e;
endpackage

// File: rtl/xmc_run_filter.sv
module xmc_run_filter #(
  parameter int EN_FILT  = 8,
  parameter int DIS_FILT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic hi_ok_o,
  output logic lo_ok_o
);
  localparam int MAXC = (EN_FILT > DIS_FILT) ? EN_FILT : DIS_FILT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] MAX_V = CW'(MAXC);
  localparam logic [CW-1:0] EN_V  = CW'(EN_FILT);
  localparam logic [CW-1:0] DIS_V = CW'(DIS_FILT);

  logic          en_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] run;

  // length of the current run of equal samples, including this edge
  always_comb begin
    if (en_i == en_q) run = (cnt_q == MAX_V) ? cnt_q : cnt_q + 1'b1;
    else              run = CW'(1);
  end

  assign hi_ok_o = en_i  && (run >= EN_V);
  assign lo_ok_o = !en_i && (run >= DIS_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q  <= en_i;
      cnt_q <= run;
    end
  end

  AST_RESTART_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i != en_q && EN_FILT > 1 && DIS_FILT > 1) |-> (!hi_ok_o && !lo_ok_o)); // R4
endmodule

// File: rtl/xmc_mode_fsm.sv
module xmc_mode_fsm
  import xmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  logic  wake_i,
  input  logic  hi_ok_i,
  input  logic  lo_ok_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_SLEEP: begin
        if (hi_ok_i)     mode_d = MODE_NORMAL;
        else if (wake_i) mode_d = MODE_STANDBY;
      end
      MODE_STANDBY: begin
        if (hi_ok_i) mode_d = MODE_NORMAL;
      end
      MODE_NORMAL: begin
        if (!en_i && wake_i) mode_d = MODE_STANDBY;
        else if (lo_ok_i)    mode_d = MODE_SLEEP;
      end
      default: mode_d = MODE_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_STANDBY;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  AST_NO_STANDBY_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STANDBY) |=> (mode_q != MODE_SLEEP)); // R3
  AST_NORMAL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_NORMAL && !en_i) |=> (mode_q != MODE_NORMAL)); // R2
  AST_WAKE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NORMAL && !en_i && wake_i) |=> (mode_q == MODE_STANDBY)); // R10
  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLEEP && !en_i && wake_i) |=> (mode_q == MODE_STANDBY)); // R9
  AST_NORMAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NORMAL && en_i) |=> (mode_q == MODE_NORMAL)); // R11
endmodule

// File: rtl/xmc_pin_map.sv
module xmc_pin_map
  import xmc_pkg::*;
(
  input  mode_e mode_i,
  input  logic  en_i,
  output logic  inh_en_o,
  output logic  txd_pd_strong_o,
  output logic  rxd_hiz_o,
  output logic  wake_det_en_o
);
  always_comb begin
    inh_en_o        = 1'b1;
    txd_pd_strong_o = 1'b0;
    rxd_hiz_o       = 1'b0;
    wake_det_en_o   = 1'b0;
    unique case (mode_i)
      MODE_SLEEP: begin
        inh_en_o      = 1'b0;
        rxd_hiz_o     = 1'b1;
        wake_det_en_o = 1'b1;
      end
      MODE_STANDBY: begin
        // pins move ahead of the enable filter when the host raises en
        txd_pd_strong_o = !en_i;
        rxd_hiz_o       = en_i;
      end
      MODE_NORMAL: begin
        wake_det_en_o = !en_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl #(
  parameter int EN_FILT  = 8,
  parameter int DIS_FILT = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       wake_i,
  output logic [1:0] mode_o,
  output logic       inh_en_o,
  output logic       txd_pd_strong_o,
  output logic       rxd_hiz_o,
  output logic       wake_det_en_o
);
  import xmc_pkg::*;

  logic  hi_ok, lo_ok;
  mode_e mode;

  xmc_run_filter #(.EN_FILT(EN_FILT), .DIS_FILT(DIS_FILT)) u_filt (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .hi_ok_o(hi_ok), .lo_ok_o(lo_ok)
  );

  xmc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .wake_i(wake_i),
    .hi_ok_i(hi_ok), .lo_ok_i(lo_ok), .mode_o(mode)
  );

  xmc_pin_map u_pins (
    .mode_i(mode), .en_i(en_i), .inh_en_o(inh_en_o),
    .txd_pd_strong_o(txd_pd_strong_o), .rxd_hiz_o(rxd_hiz_o),
    .wake_det_en_o(wake_det_en_o)
  );

  assign mode_o = mode;

  AST_SLEEP_INH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> (!inh_en_o && !txd_pd_strong_o)); // R6
  AST_DET_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |-> !wake_det_en_o); // R8
endmodule

// File: tb/xcvr_mode_ctrl_tb.sv
module xcvr_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EF = 8;
  localparam int DF = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0;
  logic wake_i = 1'b0;
  logic [1:0] mode_o;
  logic inh_en_o, txd_pd_strong_o, rxd_hiz_o, wake_det_en_o;

  int n_run = 0;
  int n_fail = 0;

  // reference model state
  int  m_mode = 1;
  int  m_run = 0;
  bit  m_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_mode_ctrl #(.EN_FILT(EF), .DIS_FILT(DF)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .wake_i(wake_i), .mode_o(mode_o),
    .inh_en_o(inh_en_o), .txd_pd_strong_o(txd_pd_strong_o),
    .rxd_hiz_o(rxd_hiz_o), .wake_det_en_o(wake_det_en_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 1; m_run = 0; m_prev = 1'b0;
    end else begin
      int r;
      bit hi, lo;
      r  = (en_i == m_prev) ? m_run + 1 : 1;
      if (r > 1000) r = 1000;
      hi = en_i && (r >= EF);
      lo = !en_i && (r >= DF);
      case (m_mode)
        0: if (hi) m_mode = 2; else if (wake_i) m_mode = 1;
        1: if (hi) m_mode = 2;
        default: if (!en_i && wake_i) m_mode = 1; else if (lo) m_mode = 0;
      endcase
      m_run = r; m_prev = en_i;
    end
  end

  task automatic check(input string tag);
    logic [5:0] exp, act;
    exp[5:4] = 2'(m_mode);
    exp[3]   = (m_mode != 0);
    exp[2]   = (m_mode == 1) && !en_i;
    exp[1]   = (m_mode == 0) || (m_mode == 1 && en_i);
    exp[0]   = (m_mode == 0) || (m_mode == 2 && !en_i);
    act = {mode_o, inh_en_o, txd_pd_strong_o, rxd_hiz_o, wake_det_en_o};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t {mode,inh,pd,hiz,wdet} actual=%b expected=%b",
               tag, $time, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit wk, input string tag);
    @(negedge clk);
    en_i = en; wake_i = wk;
    #1 check(tag);
  endtask

  task automatic hold(input bit en, input int n, input string tag);
    for (int i = 0; i < n; i++) step(en, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1) check("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    hold(0, 3, "R1 after reset");
    step(0, 1, "R11 wake in standby");
    hold(0, 2, "R11");
    hold(1, EF-1, "R5 early pins / R4");
    hold(0, 3, "R4 restart");
    step(1, 0, "R5 rise");
    step(0, 0, "R5 fall");
    hold(1, EF+2, "R2 standby->normal / R7");
    step(1, 1, "R11 wake in normal en high");
    hold(1, 2, "R11");
    hold(0, DF-1, "R4 / R8 window");
    step(1, 0, "R4 glitch");
    hold(0, DF+3, "R3 normal->sleep / R6");
    hold(1, 3, "R4 short high in sleep");
    step(0, 1, "R9 wake in sleep");
    hold(0, 3, "R9 standby");
    hold(1, EF+1, "R2 to normal");
    hold(0, 4, "R8 window");
    step(0, 1, "R10 wake in window");
    hold(0, 3, "R10 standby");
    hold(1, EF+1, "R2 to normal");
    hold(0, DF-1, "R10 window");
    step(0, 1, "R10 wake at expiry");
    hold(0, 2, "R10");
    hold(1, EF+1, "R2 to normal");
    hold(0, DF+2, "R3 to sleep");
    hold(1, EF-1, "R9 filter running");
    step(1, 1, "R9 wake at enable expiry");
    hold(1, 3, "R7 normal");
    for (int k = 0; k < 3; k++) begin
      hold(0, DF+1, "R3 repeat");
      step(0, 1, "R9 wake");
      hold(1, EF, "R2 repeat");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule